// File: doc/BRIEF.md
# Clockless Parallel Framed Link Transceiver

This block sends and receives multi-channel 14-bit samples over an 8-bit parallel bus that carries no clock. A divided clock enable paces the link. Every link period the transmitter puts one word on the bus. The top bit of each word is a frame marker and the low seven bits are payload. Each channel value takes two consecutive words: the upper half first, then the lower half. Channels follow one another in index order. The marker is set only on the first word of a frame.

The receiver passes the incoming bus through a two-stage synchronizer and runs its own phase counter at the link period. Each time the marker rises, the receiver compares the phase counter with the position where it expects the edge. If the edge is off, the counter is moved one system clock earlier or later per frame until it lines up again. A word is sampled a fixed number of clocks after the marker edge, so the sample falls in the middle of the word. Once aligned, the receiver rebuilds each channel value and pulses a per-channel strobe. A lock flag tells the user whether those strobes can be trusted.

Top module: `framed_link_xcvr`

## Requirements
- R1: A bus word is {marker, payload[6:0]}. In a frame, word 2c carries bits 13:7 of channel c and word 2c+1 carries bits 6:0 of that channel.
- R2: The marker (bit 7) is 1 only on word 0 of each frame and 0 on every other word. It stays high for exactly one link period.
- R3: One link period is CLK_MHZ/LINK_MHZ system clocks (10 by default). A frame lasts 2 x active channels link periods.
- R4: `activeChans` sets how many channels each frame carries. A value of 0 acts as 1, and a value above NUM_CH acts as NUM_CH. Channels outside the active range never pulse `txSent` or `rxNew`.
- R5: The transmit data of all channels is captured once per frame, at the start of word 0. At that moment `txSent` pulses for one clock on every active channel, in the same cycle that word 0 first appears on `busOut`.
- R6: The receiver synchronizes `busIn` through two flops and samples each word DIV/2 clocks after its phase origin. In loopback, `rxData` for a channel equals the value that was sent.
- R7: `rxNew[c]` pulses for one clock when the lower half of channel c is latched. At most one bit is set in any cycle, and no bit is set while `rxLocked` is low.
- R8: `rxLocked` rises only after two consecutive marker edges that land exactly at the expected phase.
- R9: `rxLocked` falls when the word sampled at the slot where the next marker is due shows the marker low.
- R10: A marker edge away from the expected phase clears lock. It also moves the receive phase by one clock per frame: the counter holds when the edge is 1 to DIV/2-1 clocks late, and advances by two otherwise. The receiver relocks once the edge is aligned again.
- R11: The active-low reset is synchronous. It clears the dividers, the shift state, `busOut`, lock and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| activeChans | input | $clog2(NUM_CH+1) | Number of channels carried per frame |
| txData | input | NUM_CH*14 | Transmit samples, channel c at bits [14c+13:14c] |
| txSent | output | NUM_CH | One-clock pulse per active channel when its sample is captured |
| busOut | output | 8 | Transmit bus word |
| busIn | input | 8 | Receive bus word, asynchronous to the receiver phase |
| rxData | output | NUM_CH*14 | Last received sample per channel |
| rxNew | output | NUM_CH | One-clock pulse when a channel's sample is updated |
| rxLocked | output | 1 | Receiver frame alignment indicator |

## Verification
The bench loops the transmitter back into the receiver and uses several corner cases to unlock it. It delays the loopback by three clocks, then removes that delay again. This makes the marker edge arrive both late and early. A receiver that nudged the phase the wrong way, or by more than one step, would never relock or would relock with the halves swapped. The bench also suppresses the marker entirely. A design that did not watch the expected marker slot would stay locked and keep strobing stale words. It also runs channel counts of 0, 1 and above the maximum. A design without clamping would show the wrong frame period, or would raise a strobe on an inactive channel. Values whose halves differ sharply catch any swap of the upper and lower words.

// File: rtl/flink_pkg.sv
package flink_pkg;

  localparam int WORD_W   = 8;
  localparam int HALF_W   = 7;
  localparam int SAMPLE_W = 2 * HALF_W;

  typedef struct packed {
    logic txStep;    // emit the word selected by txSel
    logic txLoad;    // first word of a frame: capture transmit samples
    logic rxTake;    // sample the synchronized bus this cycle
    logic rxCommit;  // lower half sampled while locked: publish channel
  } linkStrobes_t;

endpackage

// File: rtl/flink_ctrl.sv
module flink_ctrl import flink_pkg::*; #(
  parameter int DIV    = 10,
  parameter int NUM_CH = 2,
  parameter int OFFSET = DIV / 2,
  localparam int CNT_W = $clog2(NUM_CH + 1),
  localparam int IDX_W = $clog2(2 * NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] activeChans,
  input  logic             markSync,
  output linkStrobes_t     strb,
  output logic [IDX_W-1:0] txSel,
  output logic [IDX_W-1:0] rxSel,
  output logic [NUM_CH-1:0] activeMask,
  output logic             rxLocked
);

  localparam int DIV_W = $clog2(DIV);
  localparam logic [DIV_W-1:0] PH_LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] PH_WRAP = DIV_W'(DIV - 2);
  localparam logic [DIV_W-1:0] PH_OFS  = DIV_W'(OFFSET);

  logic [CNT_W-1:0] effChans;
  logic [IDX_W-1:0] frameWords;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [IDX_W-1:0] txIdx;

  logic             prevMark;
  logic             markRise;
  logic [DIV_W-1:0] rxCnt;
  logic [DIV_W-1:0] rxCntNext;
  logic [IDX_W-1:0] rxIdx;
  logic [IDX_W-1:0] rxIdxNext;
  logic             rxTake;
  logic             missing;
  logic             goodSeen;
  logic             locked;

  // clamp the requested channel count into 1..NUM_CH
  always_comb begin
    if (activeChans == '0)
      effChans = CNT_W'(1);
    else if (activeChans > CNT_W'(NUM_CH))
      effChans = CNT_W'(NUM_CH);
    else
      effChans = activeChans;
  end

  assign frameWords = IDX_W'({effChans, 1'b0});

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign activeMask[c] = (effChans > CNT_W'(c));
  end

  // transmit pacing
  assign tick = (divCnt == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      txIdx  <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick)
        txIdx <= ((txIdx + IDX_W'(1)) >= frameWords) ? '0 : txIdx + IDX_W'(1);
    end
  end

  assign txSel = txIdx;

  // receive phase tracking
  assign markRise = markSync & ~prevMark;
  assign rxTake   = (rxCnt == PH_OFS);
  assign rxIdxNext = markSync ? '0 :
                     ((rxIdx == '1) ? rxIdx : rxIdx + IDX_W'(1));
  assign rxSel    = rxIdxNext;
  assign missing  = rxTake && !markSync && ((rxIdx + IDX_W'(1)) == frameWords);

  always_comb begin
    rxCntNext = (rxCnt == PH_LAST) ? '0 : rxCnt + DIV_W'(1);
    if (markRise && rxCnt != '0) begin
      if (rxCnt < PH_OFS)
        rxCntNext = rxCnt;                       // edge late: hold one clock
      else if (rxCnt >= PH_WRAP)
        rxCntNext = rxCnt - PH_WRAP;             // edge early: jump ahead
      else
        rxCntNext = rxCnt + DIV_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMark <= 1'b0;
      rxCnt    <= '0;
      rxIdx    <= '0;
      goodSeen <= 1'b0;
      locked   <= 1'b0;
    end else begin
      prevMark <= markSync;
      rxCnt    <= rxCntNext;
      if (rxTake)
        rxIdx <= rxIdxNext;
      if (markRise) begin
        if (rxCnt == '0) begin
          goodSeen <= 1'b1;
          if (goodSeen)
            locked <= 1'b1;
        end else begin
          goodSeen <= 1'b0;
          locked   <= 1'b0;
        end
      end else if (missing) begin
        goodSeen <= 1'b0;
        locked   <= 1'b0;
      end
    end
  end

  assign rxLocked      = locked;
  assign strb.txStep   = tick;
  assign strb.txLoad   = tick && (txIdx == '0);
  assign strb.rxTake   = rxTake;
  assign strb.rxCommit = rxTake && locked && rxIdxNext[0] && (rxIdxNext < frameWords);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);  // R3
  AST_LOCK_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(markRise));  // R8
  AST_LOSS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(markRise || missing));  // R9
  AST_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCommit |-> locked);  // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (markRise && rxCnt != '0 && rxCnt < PH_OFS) |=> (rxCnt == $past(rxCnt)));  // R10

endmodule

// File: rtl/flink_data.sv
module flink_data import flink_pkg::*; #(
  parameter int NUM_CH = 2,
  localparam int IDX_W = $clog2(2 * NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  linkStrobes_t             strb,
  input  logic [IDX_W-1:0]         txSel,
  input  logic [IDX_W-1:0]         rxSel,
  input  logic [NUM_CH-1:0]        activeMask,
  input  logic [NUM_CH*SAMPLE_W-1:0] txData,
  input  logic [WORD_W-1:0]        busIn,
  output logic [NUM_CH-1:0]        txSent,
  output logic [WORD_W-1:0]        busOut,
  output logic [NUM_CH*SAMPLE_W-1:0] rxData,
  output logic [NUM_CH-1:0]        rxNew,
  output logic                     markSync
);

  logic [SAMPLE_W-1:0] shadow [NUM_CH];
  logic [SAMPLE_W-1:0] txPick;
  logic [WORD_W-1:0]   syncA;
  logic [WORD_W-1:0]   syncB;
  logic [HALF_W-1:0]   upperHold;

  // transmit: capture on the first word, then serve halves from the shadow
  for (genvar c = 0; c < NUM_CH; c++) begin : g_tx
    always_ff @(posedge clk) begin
      if (!rstN)
        shadow[c] <= '0;
      else if (strb.txLoad)
        shadow[c] <= txData[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  always_comb begin
    txPick = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (txSel[IDX_W-1:1] == (IDX_W-1)'(c))
        txPick = strb.txLoad ? txData[c*SAMPLE_W +: SAMPLE_W] : shadow[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOut <= '0;
      txSent <= '0;
    end else begin
      txSent <= strb.txLoad ? activeMask : '0;
      if (strb.txStep)
        busOut <= {strb.txLoad, txSel[0] ? txPick[HALF_W-1:0] : txPick[SAMPLE_W-1:HALF_W]};
    end
  end

  // receive: two-stage synchronizer, half assembly
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      upperHold <= '0;
    end else begin
      syncA <= busIn;
      syncB <= syncA;
      if (strb.rxTake && !rxSel[0])
        upperHold <= syncB[HALF_W-1:0];
    end
  end

  assign markSync = syncB[WORD_W-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rx
    logic hit;
    assign hit = strb.rxCommit && activeMask[c] && (rxSel[IDX_W-1:1] == (IDX_W-1)'(c));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxData[c*SAMPLE_W +: SAMPLE_W] <= '0;
        rxNew[c] <= 1'b0;
      end else begin
        rxNew[c] <= hit;
        if (hit)
          rxData[c*SAMPLE_W +: SAMPLE_W] <= {upperHold, syncB[HALF_W-1:0]};
      end
    end
  end

  AST_SENT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|txSent) |=> (txSent == '0));  // R5
  AST_SENT_ON_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (|txSent) |-> busOut[WORD_W-1]);  // R2
  AST_MARK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOut[WORD_W-1]) |=> busOut[WORD_W-1]);  // R2
  AST_NEW_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxNew));  // R7

endmodule

// File: rtl/framed_link_xcvr.sv
module framed_link_xcvr import flink_pkg::*; #(
  parameter int CLK_MHZ  = 100,
  parameter int LINK_MHZ = 10,
  parameter int NUM_CH   = 2,
  localparam int DIV     = CLK_MHZ / LINK_MHZ,
  localparam int OFFSET  = DIV / 2,
  localparam int CNT_W   = $clog2(NUM_CH + 1),
  localparam int IDX_W   = $clog2(2 * NUM_CH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CNT_W-1:0]             activeChans,
  input  logic [NUM_CH*SAMPLE_W-1:0]   txData,
  output logic [NUM_CH-1:0]            txSent,
  output logic [WORD_W-1:0]            busOut,
  input  logic [WORD_W-1:0]            busIn,
  output logic [NUM_CH*SAMPLE_W-1:0]   rxData,
  output logic [NUM_CH-1:0]            rxNew,
  output logic                         rxLocked
);

  linkStrobes_t      strb;
  logic [IDX_W-1:0]  txSel;
  logic [IDX_W-1:0]  rxSel;
  logic [NUM_CH-1:0] activeMask;
  logic              markSync;

  flink_ctrl #(.DIV(DIV), .NUM_CH(NUM_CH), .OFFSET(OFFSET)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .activeChans(activeChans),
    .markSync   (markSync),
    .strb       (strb),
    .txSel      (txSel),
    .rxSel      (rxSel),
    .activeMask (activeMask),
    .rxLocked   (rxLocked)
  );

  flink_data #(.NUM_CH(NUM_CH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txSel     (txSel),
    .rxSel     (rxSel),
    .activeMask(activeMask),
    .txData    (txData),
    .busIn     (busIn),
    .txSent    (txSent),
    .busOut    (busOut),
    .rxData    (rxData),
    .rxNew     (rxNew),
    .markSync  (markSync)
  );

endmodule

// File: tb/framed_link_xcvr_test.sv
`timescale 1ns/1ps
module framed_link_xcvr_test;

  localparam int NCH = 2;
  localparam int DIVB = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        activeChans = 2'd2;
  logic [NCH*14-1:0] txData = '0;
  logic [NCH-1:0]    txSent;
  logic [7:0]        busOut;
  logic [7:0]        busIn;
  logic [NCH*14-1:0] rxData;
  logic [NCH-1:0]    rxNew;
  logic              rxLocked;

  logic       addDelay = 1'b0;
  logic       cutMark = 1'b0;
  logic [7:0] d1, d2, d3;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    d1 <= busOut;
    d2 <= d1;
    d3 <= d2;
  end

  always_comb begin
    busIn = addDelay ? d3 : busOut;
    if (cutMark) busIn[7] = 1'b0;
  end

  framed_link_xcvr #(.CLK_MHZ(100), .LINK_MHZ(10), .NUM_CH(NCH)) uut (
    .clk(clk), .rstN(rstN), .activeChans(activeChans), .txData(txData),
    .txSent(txSent), .busOut(busOut), .busIn(busIn), .rxData(rxData),
    .rxNew(rxNew), .rxLocked(rxLocked)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic waitSent(output bit seen);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (|txSent) seen = 1;
    end
  endtask

  task automatic waitLock(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (rxLocked) seen = 1;
    end
  endtask

  task automatic waitUnlock(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (!rxLocked) seen = 1;
    end
  endtask

  // R6 R7: wait for a channel strobe and compare the sample
  task automatic rxExpect(input int c, input logic [13:0] exp, input string tag);
    bit seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk);
      if (rxNew[c]) seen = 1;
    end
    chk(seen, {tag, " R7 strobe"}, 32'(seen), 1);
    chk(rxData[c*14 +: 14] == exp, {tag, " R6 data"}, 32'(rxData[c*14 +: 14]), 32'(exp));
    @(negedge clk);
    chk(rxNew[c] == 1'b0, {tag, " R7 width"}, 32'(rxNew[c]), 0);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    chk(txSent == '0, "R11 txSent", 32'(txSent), 0);
    chk(rxNew == '0, "R11 rxNew", 32'(rxNew), 0);
    chk(rxLocked == 1'b0, "R11 lock", 32'(rxLocked), 0);
    chk(busOut == '0, "R11 busOut", 32'(busOut), 0);
    rstN = 1'b1;
  endtask

  task automatic tAcquire();
    bit seen;
    repeat (30) @(negedge clk);
    chk(rxLocked == 1'b0, "R8 early lock", 32'(rxLocked), 0);
    waitLock(1500, seen);
    chk(seen, "R8 lock acquired", 32'(seen), 1);
  endtask

  task automatic tFormat();
    bit seen;
    int hi;
    logic [13:0] a = 14'h2F81;
    logic [13:0] b = 14'h0ABC;
    txData = {b, a};
    waitSent(seen);
    waitSent(seen);
    chk(txSent == 2'b11, "R5 sent mask", 32'(txSent), 3);
    chk(busOut == {1'b1, a[13:7]}, "R1 word0", 32'(busOut), 32'({1'b1, a[13:7]}));
    @(negedge clk);
    chk(txSent == 2'b00, "R5 sent width", 32'(txSent), 0);
    repeat (DIVB - 1) @(negedge clk);
    chk(busOut == {1'b0, a[6:0]}, "R1 word1", 32'(busOut), 32'({1'b0, a[6:0]}));
    repeat (DIVB) @(negedge clk);
    chk(busOut == {1'b0, b[13:7]}, "R1 word2", 32'(busOut), 32'({1'b0, b[13:7]}));
    repeat (DIVB) @(negedge clk);
    chk(busOut == {1'b0, b[6:0]}, "R1 word3", 32'(busOut), 32'({1'b0, b[6:0]}));
    hi = 0;
    for (int i = 0; i < 4 * DIVB; i++) begin
      @(negedge clk);
      if (busOut[7]) hi++;
    end
    chk(hi == DIVB, "R2 marker width", 32'(hi), DIVB);
  endtask

  task automatic measurePeriod(input int exp, input string tag);
    bit seen;
    int n = 0;
    waitSent(seen);
    waitSent(seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      n++;
      if (|txSent) seen = 1;
    end
    chk(n == exp, tag, 32'(n), 32'(exp));
  endtask

  task automatic tData();
    logic [13:0] pats [4] = '{14'h3FFF, 14'h0000, 14'h3F80, 14'h007F};
    bit seen;
    for (int p = 0; p < 4; p++) begin
      txData = {pats[(p + 1) % 4], pats[p]};
      waitSent(seen);
      waitSent(seen);
      rxExpect(0, pats[p], "ch0");
      rxExpect(1, pats[(p + 1) % 4], "ch1");
    end
  endtask

  task automatic tChanCount();
    bit seen;
    int n0 = 0;
    int n1 = 0;
    activeChans = 2'd1;
    measurePeriod(2 * DIVB, "R3 R4 period one channel");
    chk(txSent == 2'b01, "R4 sent mask one", 32'(txSent), 1);
    waitLock(800, seen);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rxNew[0]) n0++;
      if (rxNew[1]) n1++;
    end
    chk(n1 == 0, "R4 inactive rxNew", 32'(n1), 0);
    chk(n0 >= 10, "R4 active rxNew", 32'(n0), 15);
    activeChans = 2'd0;
    measurePeriod(2 * DIVB, "R4 zero clamps to one");
    activeChans = 2'd3;
    measurePeriod(4 * DIVB, "R4 above max clamps");
    activeChans = 2'd2;
    measurePeriod(4 * DIVB, "R3 period two channels");
    waitLock(800, seen);
    chk(seen, "R8 relock after count change", 32'(seen), 1);
  endtask

  task automatic tMissing();
    bit seen;
    int n = 0;
    cutMark = 1'b1;
    waitUnlock(60, seen);
    chk(seen, "R9 lock lost on missing marker", 32'(seen), 1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (|rxNew) n++;
    end
    chk(n == 0, "R7 no strobe unlocked", 32'(n), 0);
    cutMark = 1'b0;
    waitLock(600, seen);
    chk(seen, "R8 relock after marker returns", 32'(seen), 1);
  endtask

  task automatic tDrift();
    bit seen;
    txData = {14'h1555, 14'h2AAA};
    addDelay = 1'b1;
    waitUnlock(60, seen);
    chk(seen, "R10 late edge drops lock", 32'(seen), 1);
    waitLock(800, seen);
    chk(seen, "R10 relock after late shift", 32'(seen), 1);
    rxExpect(0, 14'h2AAA, "R10 late");
    addDelay = 1'b0;
    waitUnlock(60, seen);
    chk(seen, "R10 early edge drops lock", 32'(seen), 1);
    waitLock(800, seen);
    chk(seen, "R10 relock after early shift", 32'(seen), 1);
    rxExpect(1, 14'h1555, "R10 early");
  endtask

  task automatic tMidReset();
    bit seen;
    waitSent(seen);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rxLocked == 1'b0, "R11 mid lock", 32'(rxLocked), 0);
    chk(txSent == '0 && rxNew == '0, "R11 mid strobes", 32'({txSent, rxNew}), 0);
    chk(busOut == '0, "R11 mid busOut", 32'(busOut), 0);
    rstN = 1'b1;
    waitLock(1500, seen);
    chk(seen, "R8 relock after reset", 32'(seen), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all actual=running expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    tReset();
    tAcquire();
    tFormat();
    tData();
    tChanCount();
    tMissing();
    tDrift();
    tMidReset();
    summary();
  end

endmodule